// File: doc/BRIEF.md
# Recovered Clock Reference Selector

This block takes the recovered line clocks of eight receive links and steers one of them onto each of two reference clock outputs, A and B. Each output has its own link index and its own fallback choice. The outputs work independently of each other, so they can pick different links or the same link.

While the chosen link reports loss of signal, the output does not carry that link's clock. It carries a substitute instead. The substitute is either the free-running master clock from the local oscillator or a steady logic high, as the output's hold bit selects. A status flag per output reads 1 while the substitute is engaged.

Every change of source is glitch-free. This covers a new link index, a loss-of-signal flag that asserts or clears, and a flip of the hold bit. The handover is break-before-make: the old source is switched off on its own falling edge, and only then is the new source switched on, on its own falling edge. The loss flags are brought into each candidate clock domain through a two-flop synchronizer before they are used. There is no data stream in this block. All pins are plain clock, control and status signals, so no valid/ready handshake applies.

Top module: `refclk_ref_select`

## Requirements
- R1: While `rst_n` is low, both reference outputs and both status flags are 0. After reset is released with both link indices at 0 and no loss flag set, both outputs carry `link_clk[0]`.
- R2: Each output carries the recovered clock `link_clk[i]`, where `i` is the binary value of its own 3-bit index (`sel_a` or `sel_b`). Each output follows its own index only.
- R3: When the selected link's loss flag (`link_los[i]`, active high) is 1 and the output's hold bit is 0, the output carries `mclk` and its status flag is 1.
- R4: When the selected link's loss flag is 1 and the output's hold bit is 1, the output stays at a constant 1 and its status flag is 1.
- R5: When the selected link's loss flag returns to 0, or the index moves to a link without loss, the output carries that link's clock again and its status flag returns to 0.
- R6: A loss flag on a link that an output does not select has no effect on that output or on its status flag.
- R7: No more than one source drives an output at any time. Every high or low level on an output lasts at least half a period of the fastest source, including across any source change.
- R8: Both outputs may select the same link at the same time, and both then carry that link's clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset |
| mclk | input | 1 | Free-running master clock, used as a substitute source |
| link_clk | input | 8 | Recovered clocks, one per receive link |
| link_los | input | 8 | Loss-of-signal flags, one per link, active high |
| sel_a | input | 3 | Link index for output A |
| hold_high_a | input | 1 | Substitute choice for output A: 1 = constant high, 0 = master clock |
| sel_b | input | 3 | Link index for output B |
| hold_high_b | input | 1 | Substitute choice for output B |
| ref_a | output | 1 | Reference clock output A |
| sub_a | output | 1 | 1 while output A carries its substitute |
| ref_b | output | 1 | Reference clock output B |
| sub_b | output | 1 | 1 while output B carries its substitute |

## Verification
Every link clock runs at its own distinct period. This lets the period measured on an output name the source that drives it, and a run of all-high samples identifies the constant-high substitute. The stimulus covers several cases: different links on the two outputs, loss on a selected link with each hold setting, loss on an unselected link, recovery by clearing the flag and by moving the index, and a shared link on both outputs. Together these show whether a fault lies in the index decode, the loss lookup, the substitute choice or coupling between the outputs. A pulse-width monitor runs through every handover and catches runt pulses or overlapping sources.

// File: rtl/refsel_pkg.sv
package refsel_pkg;
  localparam int unsigned NUM_LINKS   = 8;
  localparam int unsigned SYNC_DEPTH  = 2;
  localparam int unsigned SRC_EXTRA   = 2;
  localparam int unsigned SRC_MCLK_OF = 0;
  localparam int unsigned SRC_HIGH_OF = 1;
endpackage

// File: rtl/refsel_sync.sv
module refsel_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) stg[k] <= '0;
    end else begin
      stg[0] <= d;
      for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/refsel_gate_cell.sv
module refsel_gate_cell #(
  parameter bit CONST_HIGH = 1'b0,
  parameter int STAGES     = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic want,
  input  logic others_on,
  output logic en,
  output logic gclk
);
  logic req_s;

  // request crosses into this source's domain only once every other source is off
  refsel_sync #(.W(1), .STAGES(STAGES)) u_req (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (want & ~others_on),
    .q    (req_s)
  );

  // enable moves only while this clock is low
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) en <= 1'b0;
    else        en <= req_s;
  end

  generate
    if (CONST_HIGH) begin : g_level
      assign gclk = en;
    end else begin : g_clock
      assign gclk = clk & en;
    end
  endgenerate

  // R7: a source turns on only after all others are off
  a_r7_make_after_break: assert property (@(negedge clk) disable iff (!rst_n)
    $rose(en) |-> !others_on);
endmodule

// File: rtl/refsel_channel.sv
module refsel_channel #(
  parameter int N_LINKS = 8,
  parameter int STAGES  = 2,
  localparam int SEL_W  = $clog2(N_LINKS),
  localparam int N_SRC  = N_LINKS + refsel_pkg::SRC_EXTRA,
  localparam int I_MCLK = N_LINKS + refsel_pkg::SRC_MCLK_OF,
  localparam int I_HIGH = N_LINKS + refsel_pkg::SRC_HIGH_OF
) (
  input  logic               rst_n,
  input  logic               mclk,
  input  logic [N_LINKS-1:0] link_clk,
  input  logic [N_LINKS-1:0] los_local,
  input  logic [N_LINKS-1:0] los_mclk,
  input  logic [SEL_W-1:0]   sel,
  input  logic               hold_high,
  output logic               ref_clk,
  output logic               sub_active
);
  logic [N_SRC-1:0] want;
  logic [N_SRC-1:0] en;
  logic [N_SRC-1:0] gclk;
  logic [N_SRC-1:0] others_on;
  logic             sel_lost;

  assign sel_lost = los_mclk[sel];

  generate
    for (genvar i = 0; i < N_SRC; i++) begin : g_other
      assign others_on[i] = |(en & ~(N_SRC'(1) << i));
    end

    for (genvar i = 0; i < N_LINKS; i++) begin : g_link
      assign want[i] = (sel == SEL_W'(i)) & ~los_local[i];
      refsel_gate_cell #(.CONST_HIGH(1'b0), .STAGES(STAGES)) u_cell (
        .clk      (link_clk[i]),
        .rst_n    (rst_n),
        .want     (want[i]),
        .others_on(others_on[i]),
        .en       (en[i]),
        .gclk     (gclk[i])
      );
    end
  endgenerate

  assign want[I_MCLK] = sel_lost & ~hold_high;
  assign want[I_HIGH] = sel_lost &  hold_high;

  refsel_gate_cell #(.CONST_HIGH(1'b0), .STAGES(STAGES)) u_mclk (
    .clk      (mclk),
    .rst_n    (rst_n),
    .want     (want[I_MCLK]),
    .others_on(others_on[I_MCLK]),
    .en       (en[I_MCLK]),
    .gclk     (gclk[I_MCLK])
  );

  refsel_gate_cell #(.CONST_HIGH(1'b1), .STAGES(STAGES)) u_high (
    .clk      (mclk),
    .rst_n    (rst_n),
    .want     (want[I_HIGH]),
    .others_on(others_on[I_HIGH]),
    .en       (en[I_HIGH]),
    .gclk     (gclk[I_HIGH])
  );

  assign ref_clk    = |gclk;
  assign sub_active = en[I_MCLK] | en[I_HIGH];

  // R7: never two sources at once
  a_r7_single_source: assert property (@(posedge mclk) disable iff (!rst_n)
    $onehot0(en));

  // R3: substitute engages only after loss on the selected link was seen
  a_r3_sub_needs_los: assert property (@(posedge mclk) disable iff (!rst_n)
    $rose(sub_active) |-> $past(sel_lost));

  // R4: level substitute engages only with the hold bit set
  a_r4_high_needs_hold: assert property (@(posedge mclk) disable iff (!rst_n)
    $rose(en[I_HIGH]) |-> hold_high);
endmodule

// File: rtl/refclk_ref_select.sv
module refclk_ref_select #(
  parameter int N_LINKS = refsel_pkg::NUM_LINKS,
  parameter int STAGES  = refsel_pkg::SYNC_DEPTH,
  localparam int SEL_W  = $clog2(N_LINKS)
) (
  input  logic               rst_n,
  input  logic               mclk,
  input  logic [N_LINKS-1:0] link_clk,
  input  logic [N_LINKS-1:0] link_los,
  input  logic [SEL_W-1:0]   sel_a,
  input  logic               hold_high_a,
  input  logic [SEL_W-1:0]   sel_b,
  input  logic               hold_high_b,
  output logic               ref_a,
  output logic               sub_a,
  output logic               ref_b,
  output logic               sub_b
);
  logic [N_LINKS-1:0] los_mclk;
  logic [N_LINKS-1:0] los_local;

  refsel_sync #(.W(N_LINKS), .STAGES(STAGES)) u_los_m (
    .clk  (mclk),
    .rst_n(rst_n),
    .d    (link_los),
    .q    (los_mclk)
  );

  generate
    for (genvar i = 0; i < N_LINKS; i++) begin : g_los
      refsel_sync #(.W(1), .STAGES(STAGES)) u_los_l (
        .clk  (link_clk[i]),
        .rst_n(rst_n),
        .d    (link_los[i]),
        .q    (los_local[i])
      );
    end
  endgenerate

  refsel_channel #(.N_LINKS(N_LINKS), .STAGES(STAGES)) u_ch_a (
    .rst_n     (rst_n),
    .mclk      (mclk),
    .link_clk  (link_clk),
    .los_local (los_local),
    .los_mclk  (los_mclk),
    .sel       (sel_a),
    .hold_high (hold_high_a),
    .ref_clk   (ref_a),
    .sub_active(sub_a)
  );

  refsel_channel #(.N_LINKS(N_LINKS), .STAGES(STAGES)) u_ch_b (
    .rst_n     (rst_n),
    .mclk      (mclk),
    .link_clk  (link_clk),
    .los_local (los_local),
    .los_mclk  (los_mclk),
    .sel       (sel_b),
    .hold_high (hold_high_b),
    .ref_clk   (ref_b),
    .sub_active(sub_b)
  );
endmodule

// File: tb/sim_refclk_ref_select.sv
`timescale 1ns/1ps
module sim_refclk_ref_select;
  logic       rst_n = 1'b0;
  logic       mclk  = 1'b0;
  logic [7:0] link_clk;
  logic [7:0] link_los = '0;
  logic [2:0] sel_a = '0, sel_b = '0;
  logic       hold_high_a = 1'b0, hold_high_b = 1'b0;
  logic       ref_a, sub_a, ref_b, sub_b;

  always #2.5 mclk = ~mclk;   // 200 MHz

  generate
    for (genvar g = 0; g < 8; g++) begin : g_clk
      logic c = 1'b0;
      always #(3.0 + g) c = ~c;  // period 6 + 2*g ns
      assign link_clk[g] = c;
    end
  endgenerate

  refclk_ref_select u0 (
    .rst_n(rst_n), .mclk(mclk), .link_clk(link_clk), .link_los(link_los),
    .sel_a(sel_a), .hold_high_a(hold_high_a), .sel_b(sel_b), .hold_high_b(hold_high_b),
    .ref_a(ref_a), .sub_a(sub_a), .ref_b(ref_b), .sub_b(sub_b)
  );

  typedef struct {
    int    ch;
    real   per;
    bit    sub;
    string tag;
  } exp_t;

  exp_t q[$];
  int   n_checks = 0;
  int   n_fail   = 0;
  bit   run_done = 0;
  event go, done;

  task automatic check(input bit ok, input string tag, input string what,
                       input real act, input real exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0.2f expected=%0.2f", tag, what, act, exp);
    end
  endtask

  task automatic push(input int ch, input real per, input bit sub, input string tag);
    exp_t e;
    e.ch = ch; e.per = per; e.sub = sub; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic settle_and_check();
    #400;
    -> go;
    @(done);
  endtask

  function automatic logic out_of(input int ch);
    return (ch == 0) ? ref_a : ref_b;
  endfunction

  function automatic logic sub_of(input int ch);
    return (ch == 0) ? sub_a : sub_b;
  endfunction

  // monitor: pops expectations and measures the outputs
  initial begin
    forever begin
      @(go);
      while (q.size() > 0) begin
        exp_t e;
        real  r1, r2, per;
        int   rises;
        bit   all_high;
        logic prev, v;
        e = q.pop_front();
        rises = 0; r1 = 0.0; r2 = 0.0; all_high = 1;
        #0.25;
        prev = out_of(e.ch);
        for (int k = 0; k < 200; k++) begin
          #0.5;
          v = out_of(e.ch);
          if (v !== 1'b1) all_high = 0;
          if (v === 1'b1 && prev === 1'b0) begin
            rises++;
            if (rises == 1) r1 = $realtime;
            else if (rises == 2) r2 = $realtime;
          end
          prev = v;
        end
        per = (rises >= 2) ? (r2 - r1) : 0.0;
        if (e.per == 0.0)
          check(all_high, e.tag, $sformatf("ch%0d constant high", e.ch),
                all_high ? 1.0 : 0.0, 1.0);
        else
          check((per > e.per - 0.6) && (per < e.per + 0.6), e.tag,
                $sformatf("ch%0d period", e.ch), per, e.per);
        check(sub_of(e.ch) === e.sub, e.tag, $sformatf("ch%0d status", e.ch),
              real'(sub_of(e.ch)), real'(e.sub));
        #0.25;
      end
      -> done;
    end
  end

  // R7 pulse-width monitors
  real last_a = -1.0, last_b = -1.0;
  int  glitch_a = 0, glitch_b = 0;
  bit  mon_on = 0;

  always @(ref_a) if (mon_on) begin
    if (last_a >= 0.0 && ($realtime - last_a) < 2.4) glitch_a++;
    last_a = $realtime;
  end
  always @(ref_b) if (mon_on) begin
    if (last_b >= 0.0 && ($realtime - last_b) < 2.4) glitch_b++;
    last_b = $realtime;
  end

  initial begin
    #50;
    check(ref_a === 1'b0 && ref_b === 1'b0, "R1", "outputs in reset",
          real'(ref_a) + real'(ref_b), 0.0);
    check(sub_a === 1'b0 && sub_b === 1'b0, "R1", "status in reset",
          real'(sub_a) + real'(sub_b), 0.0);
    #50 rst_n = 1'b1;
    mon_on = 1;
    push(0, 6.0, 0, "R1"); push(1, 6.0, 0, "R1");
    settle_and_check();

    sel_a = 3'd3; sel_b = 3'd6;
    push(0, 12.0, 0, "R2"); push(1, 18.0, 0, "R2");
    settle_and_check();

    link_los[3] = 1'b1;
    push(0, 5.0, 1, "R3"); push(1, 18.0, 0, "R6");
    settle_and_check();

    hold_high_a = 1'b1;
    push(0, 0.0, 1, "R4");
    settle_and_check();

    link_los[3] = 1'b0;
    push(0, 12.0, 0, "R5");
    settle_and_check();

    link_los[7] = 1'b1; hold_high_b = 1'b1;
    #100 sel_b = 3'd7;
    push(1, 0.0, 1, "R4"); push(0, 12.0, 0, "R6");
    settle_and_check();

    sel_b = 3'd2;
    push(1, 10.0, 0, "R5");
    settle_and_check();

    sel_a = 3'd5; sel_b = 3'd5;
    push(0, 16.0, 0, "R8"); push(1, 16.0, 0, "R8");
    settle_and_check();

    link_los[0] = 1'b1;
    push(0, 16.0, 0, "R6"); push(1, 16.0, 0, "R6");
    settle_and_check();

    hold_high_a = 1'b0; link_los[5] = 1'b1;
    push(0, 5.0, 1, "R3"); push(1, 0.0, 1, "R4");
    settle_and_check();

    check(glitch_a == 0, "R7", "short pulses on A", real'(glitch_a), 0.0);
    check(glitch_b == 0, "R7", "short pulses on B", real'(glitch_b), 0.0);

    run_done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #1000000;
    if (!run_done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule